// File: doc/BRIEF.md
# First/Next Memory Error Capture Logger

This block sits beside a memory controller's ECC checker and keeps a record of memory errors for software. Each clock cycle it may receive a correctable event, an uncorrectable event, or both, each with its own physical address and, for correctable events, a 16-bit syndrome. The block keeps the first error of each type in full: the 4 KiB block address, plus the syndrome for correctable errors. Any later error of the same type only raises an overflow flag in a separate next-error status register.

Software reads the status, the address logs and the syndrome log through a small register port. It clears status bits by writing ones to them, and clearing a first-error bit lets the next error of that type be captured. The block also works out which memory channel failed from the logged correctable syndrome. It raises an interrupt level while any status bit is set.

Top module: `ecc_err_logger`

## Requirements
- R1: The first-error status register (offset 0) uses bit 0 for correctable and bit 1 for uncorrectable. An event whose first-error bit is clear sets that bit one cycle later and logs its address, plus the syndrome for correctable events.
- R2: The next-error status register (offset 1) uses the same bit encoding. An event whose first-error bit is already set sets only its next-error bit and leaves the logged address and syndrome unchanged.
- R3: The correctable address log (offset 2) and the uncorrectable address log (offset 3) are 32 bits wide. Bits 27:6 hold physical address bits 33:12, and bits 31:28 and 5:0 read as zero.
- R4: The syndrome register (offset 4) holds the 16-bit syndrome of the logged correctable error in bits 15:0.
- R5: The channel is derived from the logged syndrome and appears on `ce_chan` and in bit 16 of offset 4. If the upper byte is zero the channel is 0. Otherwise, if the lower byte is zero the channel is 1. Otherwise, if bits 15:12 or bits 11:8 are zero the channel is 0. In every other case it is 1.
- R6: Writing ones to bits 1:0 of offset 0 or offset 1 clears those status bits, and writing zeros has no effect. Clearing leaves the logs intact and re-arms capture of the next event of that type.
- R7: A correctable and an uncorrectable event in the same cycle are both captured, each in its own log.
- R8: `irq` is high exactly while any first-error or next-error status bit is set.
- R9: Reads of offsets 5 to 7 return zero.
- R10: After reset, all status bits, logs and `irq` are zero.
- R11: When a clear and an event of the same type fall in the same cycle, the event is judged against the status held before the write. If the first-error bit was set, the event sets both status bits again and does not overwrite the log.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_evt | input | 1 | Correctable error event this cycle |
| ce_addr | input | 34 | Physical address of the correctable error |
| ce_syn | input | 16 | Syndrome of the correctable error |
| ue_evt | input | 1 | Uncorrectable error event this cycle |
| ue_addr | input | 34 | Physical address of the uncorrectable error |
| reg_addr | input | 3 | Register offset for read and write |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data (ones clear status bits) |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ce_chan | output | 1 | Channel derived from the logged syndrome |
| irq | output | 1 | High while any status bit is set |

## Verification
The bench sweeps every combination of zero and non-zero syndrome nibbles. A decoder that checks the nibbles in the wrong order, or checks a nibble before the whole bytes, gives the wrong channel for some of those patterns. Repeated events of one type are injected to catch a logger that overwrites its first capture or fails to raise the overflow flag. Mixed write patterns catch a clear that touches the wrong bit or wipes the logs. A clear that lands in the same cycle as a new event catches a design that lets the clear win and re-captures the address.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
    localparam int PA_W    = 34;   // physical address width
    localparam int BLK_LSB = 12;   // 4 KiB block boundary
    localparam int LOG_LSB = 6;    // field position of block number in log
    localparam int SYN_W   = 16;
    localparam int DATA_W  = 32;
    localparam int REG_AW  = 3;
    localparam int NTYPES  = 2;
    localparam int T_CE    = 0;    // status bit for correctable
    localparam int T_UE    = 1;    // status bit for uncorrectable

    localparam logic [REG_AW-1:0] OFS_FIRST   = 3'd0;
    localparam logic [REG_AW-1:0] OFS_NEXT    = 3'd1;
    localparam logic [REG_AW-1:0] OFS_CE_ADDR = 3'd2;
    localparam logic [REG_AW-1:0] OFS_UE_ADDR = 3'd3;
    localparam logic [REG_AW-1:0] OFS_CE_SYN  = 3'd4;
endpackage

// File: rtl/ecc_chan_decode.sv
// Maps a syndrome to the failing channel.
// Assumes a 16-bit syndrome split into two bytes, one per channel.
module ecc_chan_decode
    import ecc_log_pkg::*;
(
    input  logic [SYN_W-1:0] syn,
    output logic             chan
);
    localparam int HALF = SYN_W / 2;
    localparam int QTR  = SYN_W / 4;

    // Priority decode: whole bytes first, then the two high nibbles.
    always_comb begin
        if (syn[SYN_W-1:HALF] == '0)
            chan = 1'b0;
        else if (syn[HALF-1:0] == '0)
            chan = 1'b1;
        else if (syn[SYN_W-1 -: QTR] == '0 || syn[SYN_W-QTR-1 -: QTR] == '0)
            chan = 1'b0;
        else
            chan = 1'b1;
    end
endmodule

// File: rtl/ecc_log_slot.sv
// Holds the first/next status and the capture log for one error type.
// Assumes clr_* are write-one-to-clear masks already decoded for this slot.
module ecc_log_slot
    import ecc_log_pkg::*;
#(
    parameter bit KEEP_SYN = 1'b1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt,
    input  logic [PA_W-1:0]   addr,
    input  logic [SYN_W-1:0]  syn_in,
    input  logic              clr_first,
    input  logic              clr_next,
    output logic              first_q,
    output logic              next_q,
    output logic [DATA_W-1:0] log_q,
    output logic [SYN_W-1:0]  syn_q
);
    localparam int BLK_W = PA_W - BLK_LSB;

    logic capture;
    assign capture = evt && !first_q;

    // Status: events are judged against the pre-write first bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b0;
            next_q  <= 1'b0;
        end else begin
            first_q <= (first_q && !clr_first) || evt;
            next_q  <= (next_q && !clr_next) || (evt && first_q);
        end
    end

    // Address log: block number only, other bits held at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            log_q <= '0;
        else if (capture) begin
            log_q <= '0;
            log_q[LOG_LSB +: BLK_W] <= addr[PA_W-1:BLK_LSB];
        end
    end

    generate
        if (KEEP_SYN) begin : g_syn
            // Syndrome log for the captured event.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    syn_q <= '0;
                else if (capture)
                    syn_q <= syn_in;
            end
        end else begin : g_nosyn
            assign syn_q = '0;
        end
    endgenerate
endmodule

// File: rtl/ecc_log_regs.sv
// Read multiplexer for the logger's register window.
// Assumes reads have no side effects and unmapped offsets return zero.
module ecc_log_regs
    import ecc_log_pkg::*;
(
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [NTYPES-1:0] first_q,
    input  logic [NTYPES-1:0] next_q,
    input  logic [DATA_W-1:0] ce_log,
    input  logic [DATA_W-1:0] ue_log,
    input  logic [SYN_W-1:0]  ce_syn_q,
    input  logic              ce_chan,
    output logic [DATA_W-1:0] rdata
);
    // Select the addressed register.
    always_comb begin
        rdata = '0;
        case (reg_addr)
            OFS_FIRST:   rdata[NTYPES-1:0] = first_q;
            OFS_NEXT:    rdata[NTYPES-1:0] = next_q;
            OFS_CE_ADDR: rdata = ce_log;
            OFS_UE_ADDR: rdata = ue_log;
            OFS_CE_SYN:  rdata[SYN_W:0] = {ce_chan, ce_syn_q};
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/ecc_err_logger.sv
// First/next memory error logger top level.
// Assumes events are single-cycle pulses, synchronous to clk.
module ecc_err_logger
    import ecc_log_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_evt,
    input  logic [PA_W-1:0]   ce_addr,
    input  logic [SYN_W-1:0]  ce_syn,
    input  logic              ue_evt,
    input  logic [PA_W-1:0]   ue_addr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              ce_chan,
    output logic              irq
);
    logic [NTYPES-1:0] evt_v, clr_first, clr_next, first_q, next_q;
    logic [PA_W-1:0]   addr_v [NTYPES];
    logic [SYN_W-1:0]  syn_in_v [NTYPES];
    logic [SYN_W-1:0]  syn_q_v [NTYPES];
    logic [DATA_W-1:0] log_v [NTYPES];
    logic [DATA_W-1:0] ce_log;
    logic [DATA_W-1:0] ue_log;

    assign evt_v[T_CE]    = ce_evt;
    assign evt_v[T_UE]    = ue_evt;
    assign addr_v[T_CE]   = ce_addr;
    assign addr_v[T_UE]   = ue_addr;
    assign syn_in_v[T_CE] = ce_syn;
    assign syn_in_v[T_UE] = '0;

    // Write-one-to-clear masks for the two status registers.
    assign clr_first = (reg_we && reg_addr == OFS_FIRST) ? reg_wdata[NTYPES-1:0] : '0;
    assign clr_next  = (reg_we && reg_addr == OFS_NEXT)  ? reg_wdata[NTYPES-1:0] : '0;

    genvar t;
    generate
        for (t = 0; t < NTYPES; t++) begin : g_slot
            ecc_log_slot #(.KEEP_SYN(t == T_CE)) u_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .evt       (evt_v[t]),
                .addr      (addr_v[t]),
                .syn_in    (syn_in_v[t]),
                .clr_first (clr_first[t]),
                .clr_next  (clr_next[t]),
                .first_q   (first_q[t]),
                .next_q    (next_q[t]),
                .log_q     (log_v[t]),
                .syn_q     (syn_q_v[t])
            );
        end
    endgenerate

    assign ce_log = log_v[T_CE];
    assign ue_log = log_v[T_UE];

    ecc_chan_decode u_chan (
        .syn  (syn_q_v[T_CE]),
        .chan (ce_chan)
    );

    ecc_log_regs u_regs (
        .reg_addr (reg_addr),
        .first_q  (first_q),
        .next_q   (next_q),
        .ce_log   (ce_log),
        .ue_log   (ue_log),
        .ce_syn_q (syn_q_v[T_CE]),
        .ce_chan  (ce_chan),
        .rdata    (reg_rdata)
    );

    // Interrupt level while anything is pending.
    assign irq = |{first_q, next_q};
endmodule

// File: rtl/ecc_err_logger_chk.sv
// Temporal checks on the logger, attached by bind.
module ecc_err_logger_chk
    import ecc_log_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ce_evt,
    input logic              ue_evt,
    input logic [PA_W-1:0]   ce_addr,
    input logic [NTYPES-1:0] first_q,
    input logic [NTYPES-1:0] next_q,
    input logic [DATA_W-1:0] ce_log,
    input logic              irq
);
    // R1: a correctable event always leaves its first bit set.
    p_first_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ce_evt |=> first_q[T_CE]);

    // R2: an event that finds its first bit set raises the overflow flag.
    p_next_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ue_evt && first_q[T_UE]) |=> next_q[T_UE]);

    // R2: the log is frozen while the first bit is held.
    p_log_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        first_q[T_CE] |=> $stable(ce_log));

    // R3: a fresh capture stores the block number of the event address.
    p_addr_fmt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_evt && !first_q[T_CE]) |=> ce_log[27:6] == $past(ce_addr[33:12]));

    // R8: any event brings up the interrupt.
    p_irq_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_evt || ue_evt) |=> irq);
endmodule

bind ecc_err_logger ecc_err_logger_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_evt  (ce_evt),
    .ue_evt  (ue_evt),
    .ce_addr (ce_addr),
    .first_q (first_q),
    .next_q  (next_q),
    .ce_log  (ce_log),
    .irq     (irq)
);

// File: tb/ecc_err_logger_tb.sv
module ecc_err_logger_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_evt = 1'b0, ue_evt = 1'b0;
    logic [33:0] ce_addr = '0, ue_addr = '0;
    logic [15:0] ce_syn = '0;
    logic [2:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ce_chan, irq;

    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;  // 250 MHz

    ecc_err_logger u_dut (
        .clk(clk), .rst_n(rst_n), .ce_evt(ce_evt), .ce_addr(ce_addr),
        .ce_syn(ce_syn), .ue_evt(ue_evt), .ue_addr(ue_addr),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ce_chan(ce_chan), .irq(irq)
    );

    function automatic logic [31:0] blk(input logic [33:0] a);
        return {4'b0, a[33:12], 6'b0};
    endfunction

    function automatic logic exp_chan(input logic [15:0] s);
        if (s[15:8] == 0) return 1'b0;
        if (s[7:0] == 0)  return 1'b1;
        if (s[15:12] == 0 || s[11:8] == 0) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // All driving happens on the falling edge.
    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic evt(input logic c, input logic [33:0] ca, input logic [15:0] cs,
                       input logic u, input logic [33:0] ua);
        @(negedge clk);
        ce_evt = c; ce_addr = ca; ce_syn = cs; ue_evt = u; ue_addr = ua;
        @(negedge clk);
        ce_evt = 1'b0; ue_evt = 1'b0;
    endtask

    task automatic clear_all();
        wr(3'd0, 32'h3);
        wr(3'd1, 32'h3);
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [33:0] a1, a2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state, R9 unmapped offsets
        for (int o = 0; o < 8; o++) begin
            rd(3'(o), d);
            check(o > 4 ? "R9" : "R10", d, 32'h0);
        end
        check("R10 irq", {31'b0, irq}, 32'h0);

        // R1 first capture of a correctable error
        a1 = 34'h2_ABCD_E123;
        evt(1'b1, a1, 16'h3C00, 1'b0, '0);
        rd(3'd0, d); check("R1 first", d, 32'h1);
        rd(3'd1, d); check("R2 next clear", d, 32'h0);
        rd(3'd2, d); check("R3 ce log", d, blk(a1));
        rd(3'd4, d); check("R4/R5 syn", d, {15'b0, exp_chan(16'h3C00), 16'h3C00});
        check("R8 irq on", {31'b0, irq}, 32'h1);

        // R2 second correctable: flag only, log kept
        evt(1'b1, 34'h1_1111_1111, 16'h00FF, 1'b0, '0);
        rd(3'd1, d); check("R2 next set", d, 32'h1);
        rd(3'd2, d); check("R2 log kept", d, blk(a1));
        rd(3'd4, d); check("R2 syn kept", d, {15'b0, exp_chan(16'h3C00), 16'h3C00});

        // R1 uncorrectable capture, then R2 overflow
        a2 = 34'h3_FFFF_FFFF;
        evt(1'b0, '0, '0, 1'b1, a2);
        rd(3'd0, d); check("R1 ue first", d, 32'h3);
        rd(3'd3, d); check("R3 ue log", d, blk(a2));
        evt(1'b0, '0, '0, 1'b1, 34'h0_0000_1000);
        rd(3'd1, d); check("R2 ue next", d, 32'h3);
        rd(3'd3, d); check("R2 ue log kept", d, blk(a2));

        // R6 writing zeros does nothing; single-bit clears
        wr(3'd0, 32'hFFFF_FFFC);
        rd(3'd0, d); check("R6 zero write", d, 32'h3);
        wr(3'd0, 32'h1);
        rd(3'd0, d); check("R6 clear ce", d, 32'h2);
        rd(3'd2, d); check("R6 log intact", d, blk(a1));
        wr(3'd1, 32'h3);
        rd(3'd1, d); check("R6 clear next", d, 32'h0);
        check("R8 irq still", {31'b0, irq}, 32'h1);
        wr(3'd0, 32'h2);
        check("R8 irq off", {31'b0, irq}, 32'h0);
        rd(3'd3, d); check("R6 ue log intact", d, blk(a2));

        // R6 re-arm: next correctable is captured afresh
        evt(1'b1, 34'h0_1234_5678, 16'h0012, 1'b0, '0);
        rd(3'd2, d); check("R6 rearm log", d, blk(34'h0_1234_5678));
        rd(3'd1, d); check("R6 rearm next", d, 32'h0);

        // R11 clear and event in the same cycle
        @(negedge clk);
        reg_addr = 3'd0; reg_wdata = 32'h1; reg_we = 1'b1;
        ce_evt = 1'b1; ce_addr = 34'h2_2222_2222; ce_syn = 16'hFFFF;
        @(negedge clk);
        reg_we = 1'b0; ce_evt = 1'b0;
        rd(3'd0, d); check("R11 first", d, 32'h1);
        rd(3'd1, d); check("R11 next", d, 32'h1);
        rd(3'd2, d); check("R11 log kept", d, blk(34'h0_1234_5678));

        // R7 / R3 simultaneous events over an address sweep
        for (int i = 0; i < 8; i++) begin
            logic [33:0] ca, ua;
            ca = 34'((64'h3_5A5A_5A5A * (i + 1)) ^ (i * 977));
            ua = 34'((64'h1_C3C3_0F0F * (i + 3)) + i);
            clear_all();
            evt(1'b1, ca, 16'h0101, 1'b1, ua);
            rd(3'd0, d); check("R7 both first", d, 32'h3);
            rd(3'd2, d); check("R7/R3 ce addr", d, blk(ca));
            rd(3'd3, d); check("R7/R3 ue addr", d, blk(ua));
        end

        // R5 channel sweep over zero/non-zero nibble patterns
        for (int m = 0; m < 16; m++) begin
            for (int v = 1; v < 16; v += 7) begin
                logic [15:0] s;
                for (int k = 0; k < 4; k++)
                    s[k*4 +: 4] = m[k] ? 4'h0 : 4'((v + k * 5) % 15 + 1);
                clear_all();
                evt(1'b1, 34'h0_0000_0000, s, 1'b0, '0);
                rd(3'd4, d);
                check("R4/R5 syn reg", d, {15'b0, exp_chan(s), s});
                check("R5 ce_chan", {31'b0, ce_chan}, {31'b0, exp_chan(s)});
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule